// File: doc/BRIEF.md
# CRC-4 Command Frame Builder and Checker

This block computes the 4-bit checksum that guards single-byte memory accesses on a contactless serial link. It handles two kinds of request. For a write, it assembles the complete serial command word, made of the command bits, the data byte and the checksum, and reports the bit length of that word. For a read, it takes the 12-bit answer that came back from the card. It returns the data byte and the command word that must be sent. It also flags the answer as bad when the checksum carried in the answer differs from the one it computes.

The checksum is worked out serially, one message bit per clock, least significant bit first. The command size is the number of bits in the command word, including the operation bit. It is a runtime input, so one instance serves cards with different address widths. Requests enter on a valid/ready stream and results leave on a second valid/ready stream. A result is held unchanged until the consumer takes it. A new request can be accepted on the same edge that the previous result is taken, so back-to-back traffic loses no cycle at the output side. The request side never stalls a source for any reason except a computation in progress or a result that is being held.

Top module: `crc4_cmd_frame`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rsp_valid` and `busy` are 0 and `req_ready` is 1.
- R2: The checksum register is 4 bits wide and starts at 0x5. For each message bit b, taken LSB first, let f = reg[0] XOR b. The register is then shifted right by one, and if f is 1 it is XORed with 0xC. The final register value is the checksum, with no output XOR, and it appears on `rsp_crc`.
- R3: The command word is `{req_index, op}` masked to its lowest `sz` bits. Here op is the LSB, with 1 meaning read and 0 meaning write, and sz is the effective command size. The checksum message is `(data << sz) | command word`, processed over sz+8 bits. For a read, data is `req_resp[7:0]`; for a write, data is `req_wdata`.
- R4: For a write, `rsp_frame` carries the command word in bits [sz-1:0], the data byte in bits [sz+7:sz] and the checksum in bits [sz+11:sz+8]. All higher bits are 0, and `rsp_len` = sz+12.
- R5: For a read, `rsp_frame` is the command word alone and `rsp_len` = sz. `rsp_data` is the data byte used in the message. `rsp_err` is 1 exactly when a read's `req_resp[11:8]` differs from the computed checksum, and it is always 0 for a write.
- R6: `busy` is high from the cycle after acceptance until the checksum is finished. `rsp_valid` rises exactly sz+8 cycles after the accepting clock edge, and `busy` and `rsp_valid` are never high together.
- R7: While `rsp_valid` is high and `rsp_ready` is low, every result output holds its value.
- R8: `req_ready` is 1 when the block is idle. It is also 1 when a result is held and `rsp_ready` is 1 in that cycle, and it is 0 otherwise. A request presented while `req_ready` is 0 has no effect on any later result.
- R9: `req_cmd_sz` values above CMD_MAX are treated as CMD_MAX. Values from 0 to CMD_MAX are used as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid is also high |
| req_read | input | 1 | 1 = read check, 0 = write frame build |
| req_cmd_sz | input | CSZ_W (5) | Command size in bits, including the operation bit |
| req_index | input | CMD_MAX-1 (19) | Byte index |
| req_wdata | input | 8 | Data byte for a write |
| req_resp | input | 12 | Received answer for a read: data in [7:0], checksum in [11:8] |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumed on this edge when valid is also high |
| rsp_frame | output | FRAME_W (32) | Serial command word, LSB first |
| rsp_len | output | LEN_W (6) | Number of valid bits in `rsp_frame` |
| rsp_data | output | 8 | Data byte covered by the checksum |
| rsp_crc | output | 4 | Computed checksum |
| rsp_err | output | 1 | Read answer checksum mismatch |
| busy | output | 1 | Checksum computation in progress |

## Verification
Two events can fall on the same clock edge: a held result is drained, and a new request is accepted. The bench provokes this in a phase that keeps `req_valid` and `rsp_ready` high continuously. In that phase each accept coincides with the drain of the previous result. A later random phase mixes back-pressure, idle gaps and requests that arrive while the block is busy, with random command sizes. A behavioural model follows the handshakes cycle by cycle. It requires the new operation to start on the drain edge, with its result appearing sz+8 cycles later and carrying the new request's fields and not the old ones.

// File: rtl/crc4f_pkg.sv
package crc4f_pkg;

  localparam logic [3:0] CRC_SEED = 4'h5;
  localparam logic [3:0] CRC_POLY = 4'hC;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ctl_state_e;

  // one reflected shift step of the 4-bit checksum register
  function automatic logic [3:0] crc_step(input logic [3:0] cur, input logic din);
    logic fb;
    fb = cur[0] ^ din;
    crc_step = fb ? ((cur >> 1) ^ CRC_POLY) : (cur >> 1);
  endfunction

endpackage

// File: rtl/crc4f_msg.sv
module crc4f_msg #(
  parameter int CMD_MAX = 20,
  parameter int CSZ_W   = $clog2(CMD_MAX + 1),
  parameter int MSG_W   = CMD_MAX + 8
) (
  input  logic               op_read,
  input  logic [CSZ_W-1:0]   cmd_sz,
  input  logic [CMD_MAX-2:0] index,
  input  logic [7:0]         wdata,
  input  logic [11:0]        resp,
  output logic [CSZ_W-1:0]   sz_eff,
  output logic [CMD_MAX-1:0] cmd_word,
  output logic [7:0]         data_byte,
  output logic [MSG_W-1:0]   msg
);
  localparam logic [CSZ_W-1:0] SZ_LIMIT = CSZ_W'(CMD_MAX);

  logic [CMD_MAX-1:0] raw_cmd;

  assign sz_eff    = (cmd_sz > SZ_LIMIT) ? SZ_LIMIT : cmd_sz;
  assign raw_cmd   = {index, op_read};
  assign data_byte = op_read ? resp[7:0] : wdata;

  for (genvar i = 0; i < CMD_MAX; i++) begin : g_mask
    assign cmd_word[i] = (CSZ_W'(i) < sz_eff) ? raw_cmd[i] : 1'b0;
  end

  assign msg = (MSG_W'(data_byte) << sz_eff) | MSG_W'(cmd_word);
endmodule

// File: rtl/crc4f_serial.sv
module crc4f_serial
  import crc4f_pkg::*;
#(
  parameter int MSG_W = 28,
  parameter int CNT_W = $clog2(MSG_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MSG_W-1:0] msg,
  input  logic [CNT_W-1:0] nbits,
  output logic [3:0]       crc,
  output logic             running,
  output logic             last
);
  logic [MSG_W-1:0] shreg;
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc    <= CRC_SEED;
      shreg  <= '0;
      remain <= '0;
    end else if (load) begin
      crc    <= CRC_SEED;
      shreg  <= msg;
      remain <= nbits;
    end else if (remain != '0) begin
      crc    <= crc_step(crc, shreg[0]);
      shreg  <= shreg >> 1;
      remain <= remain - 1'b1;
    end
  end

  assign running = (remain != '0);
  assign last    = (remain == CNT_W'(1));
endmodule

// File: rtl/crc4f_ctrl.sv
module crc4f_ctrl
  import crc4f_pkg::*;
#(
  parameter int CMD_MAX = 20,
  parameter int CSZ_W   = $clog2(CMD_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               rsp_ready,
  input  logic               eng_last,
  input  logic               in_read,
  input  logic [CSZ_W-1:0]   in_sz,
  input  logic [CMD_MAX-1:0] in_cmd,
  input  logic [7:0]         in_data,
  input  logic [3:0]         in_rcrc,
  output logic               req_ready,
  output logic               accept,
  output logic               rsp_valid,
  output logic               busy,
  output logic               q_read,
  output logic [CSZ_W-1:0]   q_sz,
  output logic [CMD_MAX-1:0] q_cmd,
  output logic [7:0]         q_data,
  output logic [3:0]         q_rcrc
);
  ctl_state_e st, st_nx;

  assign req_ready = (st == ST_IDLE) || ((st == ST_DONE) && rsp_ready);
  assign accept    = req_valid && req_ready;
  assign rsp_valid = (st == ST_DONE);
  assign busy      = (st == ST_RUN);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (accept) st_nx = ST_RUN;
      ST_RUN:  if (eng_last) st_nx = ST_DONE;
      ST_DONE: if (rsp_ready) st_nx = accept ? ST_RUN : ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      q_read <= 1'b0;
      q_sz   <= '0;
      q_cmd  <= '0;
      q_data <= '0;
      q_rcrc <= '0;
    end else begin
      st <= st_nx;
      if (accept) begin
        q_read <= in_read;
        q_sz   <= in_sz;
        q_cmd  <= in_cmd;
        q_data <= in_data;
        q_rcrc <= in_rcrc;
      end
    end
  end
endmodule

// File: rtl/crc4f_pack.sv
module crc4f_pack #(
  parameter int CMD_MAX = 20,
  parameter int CSZ_W   = $clog2(CMD_MAX + 1),
  parameter int FRAME_W = CMD_MAX + 12,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               is_read,
  input  logic [CSZ_W-1:0]   sz,
  input  logic [CMD_MAX-1:0] cmd_word,
  input  logic [7:0]         data_byte,
  input  logic [3:0]         crc,
  input  logic [3:0]         rx_crc,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len,
  output logic               err
);
  logic [FRAME_W-1:0] cmd_ext, dat_sh, crc_sh;
  logic [LEN_W-1:0]   sz_ext;

  assign sz_ext  = LEN_W'(sz);
  assign cmd_ext = FRAME_W'(cmd_word);
  assign dat_sh  = FRAME_W'(data_byte) << sz_ext;
  assign crc_sh  = FRAME_W'(crc) << (sz_ext + LEN_W'(8));

  assign frame = is_read ? cmd_ext : (cmd_ext | dat_sh | crc_sh);
  assign len   = is_read ? sz_ext : (sz_ext + LEN_W'(12));
  assign err   = is_read && (rx_crc != crc);
endmodule

// File: rtl/crc4_cmd_frame.sv
module crc4_cmd_frame #(
  parameter int CMD_MAX = 20,
  parameter int CSZ_W   = $clog2(CMD_MAX + 1),
  parameter int FRAME_W = CMD_MAX + 12,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_read,
  input  logic [CSZ_W-1:0]   req_cmd_sz,
  input  logic [CMD_MAX-2:0] req_index,
  input  logic [7:0]         req_wdata,
  input  logic [11:0]        req_resp,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic [LEN_W-1:0]   rsp_len,
  output logic [7:0]         rsp_data,
  output logic [3:0]         rsp_crc,
  output logic               rsp_err,
  output logic               busy
);
  localparam int MSG_W = CMD_MAX + 8;
  localparam int CNT_W = $clog2(MSG_W + 1);

  logic [CSZ_W-1:0]   sz_eff, q_sz;
  logic [CMD_MAX-1:0] cmd_word, q_cmd;
  logic [7:0]         data_byte, q_data;
  logic [MSG_W-1:0]   msg;
  logic [3:0]         q_rcrc, eng_crc;
  logic               accept, eng_last, eng_run, q_read;

  crc4f_msg #(.CMD_MAX(CMD_MAX), .CSZ_W(CSZ_W), .MSG_W(MSG_W)) u_msg (
    .op_read(req_read), .cmd_sz(req_cmd_sz), .index(req_index),
    .wdata(req_wdata), .resp(req_resp), .sz_eff(sz_eff),
    .cmd_word(cmd_word), .data_byte(data_byte), .msg(msg)
  );

  crc4f_serial #(.MSG_W(MSG_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .load(accept), .msg(msg),
    .nbits(CNT_W'(sz_eff) + CNT_W'(8)), .crc(eng_crc),
    .running(eng_run), .last(eng_last)
  );

  crc4f_ctrl #(.CMD_MAX(CMD_MAX), .CSZ_W(CSZ_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_ready(rsp_ready),
    .eng_last(eng_last), .in_read(req_read), .in_sz(sz_eff),
    .in_cmd(cmd_word), .in_data(data_byte), .in_rcrc(req_resp[11:8]),
    .req_ready(req_ready), .accept(accept), .rsp_valid(rsp_valid),
    .busy(busy), .q_read(q_read), .q_sz(q_sz), .q_cmd(q_cmd),
    .q_data(q_data), .q_rcrc(q_rcrc)
  );

  crc4f_pack #(.CMD_MAX(CMD_MAX), .CSZ_W(CSZ_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_pack (
    .is_read(q_read), .sz(q_sz), .cmd_word(q_cmd), .data_byte(q_data),
    .crc(eng_crc), .rx_crc(q_rcrc), .frame(rsp_frame), .len(rsp_len),
    .err(rsp_err)
  );

  assign rsp_data = q_data;
  assign rsp_crc  = eng_crc;
endmodule

// File: rtl/crc4f_chk.sv
module crc4f_chk #(
  parameter int FRAME_W = 32,
  parameter int LEN_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [FRAME_W-1:0] rsp_frame,
  input logic [LEN_W-1:0]   rsp_len,
  input logic [3:0]         rsp_crc,
  input logic               rsp_err,
  input logic               busy,
  input logic               eng_run
);
  AST_LEN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_len <= LEN_W'(FRAME_W)));  // R4
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_frame >> rsp_len) == '0));  // R4
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_frame) && $stable(rsp_len)
      && $stable(rsp_crc) && $stable(rsp_err)));  // R7
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);  // R8
  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && rsp_valid));  // R6
  AST_ENGINE_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !eng_run);  // R6
  AST_FALL_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);  // R6
  AST_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!rsp_valid && !busy));  // R1
endmodule

bind crc4_cmd_frame crc4f_chk #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_frame(rsp_frame), .rsp_len(rsp_len),
  .rsp_crc(rsp_crc), .rsp_err(rsp_err), .busy(busy), .eng_run(eng_run)
);

// File: tb/sim_crc4_cmd_frame.sv
module sim_crc4_cmd_frame;
  localparam int CLK_PERIOD = 10;
  localparam int CMD_MAX = 20;
  localparam int CSZ_W   = $clog2(CMD_MAX + 1);
  localparam int FRAME_W = CMD_MAX + 12;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0, rsp_ready = 1'b0;
  logic [CSZ_W-1:0] req_cmd_sz = '0;
  logic [CMD_MAX-2:0] req_index = '0;
  logic [7:0] req_wdata = '0;
  logic [11:0] req_resp = '0;
  logic req_ready, rsp_valid, rsp_err, busy;
  logic [FRAME_W-1:0] rsp_frame;
  logic [LEN_W-1:0] rsp_len;
  logic [7:0] rsp_data;
  logic [3:0] rsp_crc;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  crc4_cmd_frame u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural checksum over n bits of m, LSB first (R2)
  function automatic int ref_crc(longint m, int n);
    int c = 5;
    for (int i = 0; i < n; i++) begin
      int fb = (c & 1) ^ int'((m >> i) & 1);
      c = c >> 1;
      if (fb != 0) c = c ^ 12;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int m_st = 0, m_cnt = 0;
  longint e_frame = 0;
  int e_len = 0, e_data = 0, e_crc = 0, e_err = 0;

  task automatic model_load();
    int sz, dat, crc;
    longint cmdw, m;
    sz = (int'(req_cmd_sz) > CMD_MAX) ? CMD_MAX : int'(req_cmd_sz);  // R9 clamp
    cmdw = ((longint'(req_index) << 1) | longint'(req_read)) & ((longint'(1) << sz) - 1);  // R3
    dat = req_read ? int'(req_resp[7:0]) : int'(req_wdata);
    m = (longint'(dat) << sz) | cmdw;
    crc = ref_crc(m, sz + 8);
    e_data = dat; e_crc = crc;
    if (req_read) begin
      e_frame = cmdw; e_len = sz; e_err = (int'(req_resp[11:8]) != crc) ? 1 : 0;
    end else begin
      e_frame = cmdw | (longint'(dat) << sz) | (longint'(crc) << (sz + 8));
      e_len = sz + 12; e_err = 0;
    end
    m_cnt = sz + 8;
    m_st = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_st = 0;
    else begin
      case (m_st)
        0: if (req_valid) model_load();
        1: begin m_cnt--; if (m_cnt == 0) m_st = 2; end
        default: if (rsp_ready) begin
          if (req_valid) model_load();  // R8 same-edge accept
          else m_st = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
      end else begin
        bit exp_rdy;
        exp_rdy = (m_st == 0) || (m_st == 2 && rsp_ready);
        chk(req_ready == exp_rdy, "R8 req_ready", req_ready, exp_rdy);
        chk(rsp_valid == (m_st == 2), "R6 rsp_valid", rsp_valid, m_st == 2);
        chk(busy == (m_st == 1), "R6 busy", busy, m_st == 1);
        if (m_st == 2) begin
          chk(rsp_frame == FRAME_W'(e_frame), "R4 R5 R3 R7 rsp_frame", rsp_frame, e_frame);
          chk(int'(rsp_len) == e_len, "R4 R5 R9 rsp_len", rsp_len, e_len);
          chk(int'(rsp_crc) == e_crc, "R2 R3 rsp_crc", rsp_crc, e_crc);
          chk(int'(rsp_data) == e_data, "R5 rsp_data", rsp_data, e_data);
          chk(int'(rsp_err) == e_err, "R5 rsp_err", rsp_err, e_err);
        end
      end
    end
  end

  task automatic drive_random(input bit force_valid, input bit force_ready);
    int sz;
    longint cmdw, m;
    req_valid  = force_valid ? 1'b1 : ($urandom_range(0, 2) != 0);
    rsp_ready  = force_ready ? 1'b1 : ($urandom_range(0, 2) == 0);
    req_read   = $urandom_range(0, 1) != 0;
    req_cmd_sz = CSZ_W'($urandom_range(0, 31));
    if ($urandom_range(0, 3) == 0) req_cmd_sz = CSZ_W'(CMD_MAX);
    req_index  = (CMD_MAX-1)'($urandom());
    req_wdata  = 8'($urandom());
    req_resp   = 12'($urandom());
    // half of the reads carry a correct checksum
    if (req_read && $urandom_range(0, 1) != 0) begin
      sz = (int'(req_cmd_sz) > CMD_MAX) ? CMD_MAX : int'(req_cmd_sz);
      cmdw = ((longint'(req_index) << 1) | 1) & ((longint'(1) << sz) - 1);
      m = (longint'(req_resp[7:0]) << sz) | cmdw;
      req_resp[11:8] = 4'(ref_crc(m, sz + 8));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // back-to-back phase: accept and drain on the same edge (R8)
    for (int i = 0; i < 1500; i++) begin
      @(posedge clk); #1 drive_random(1'b1, 1'b1);
    end
    // mixed phase: back-pressure (R7), gaps, requests while busy (R8)
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1 drive_random(1'b0, 1'b0);
    end
    @(posedge clk); #1 req_valid = 1'b0; rsp_ready = 1'b1;
    repeat (40) @(posedge clk);
    @(negedge clk); #1;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R6 actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule